// File: doc/BRIEF.md
# Credit-Based Frame Injection Controller

This block sits at a traffic source of a frame-scheduled on-chip network. It decides whether the packet that the source offers in the current cycle may enter the network, and if so, which frame number the packet carries. Time is split into a rotating window of `W` frames. One of them, the head frame, is draining and takes no new traffic. Each source may place a fixed number of flit slots (its reservation) into every frame. A signed credit counter tracks what is left of the reservation in the frame the source is filling now. An accepted packet may push the counter below zero, which lets a long packet through. When the credit is exhausted, the controller borrows reservations from later frames in the window. It stops when the frame in front of the head is reached.

The network's head pointer and its window-shift pulse are inputs. When a shift hands the head role to the frame the source is filling, the source moves one frame ahead and its credit is refilled up to the reservation. The reservation is a register that can be rewritten at run time. Accept and stall are combinational answers to the request in the same cycle. All state moves on the clock edge.

Top module: `frame_inject_ctrl`

## Requirements
- R1: After reset the credit and the reservation both equal `INIT_RESV` and the current injection frame is 1. A first request of any length from 1 to `2**LEN_W-1` is accepted with tag 1.
- R2: While the credit is above zero, a request is accepted in the current injection frame and the credit drops by `req_len`. The credit may go negative, down to no less than `-(2**LEN_W-1)`.
- R3: A request that finds the credit at zero or below moves the injection frame forward by one (modulo `W`), adding the reservation at each step. It keeps moving while the credit stays at or below zero and the next frame is not `head_frame`. The request is accepted, tagged with the final frame, only if the credit ended above zero. The frame and credit reached are kept whether or not the request is accepted.
- R4: When no frame short of the head can supply positive credit, `inj_stall` is 1 and `inj_accept` is 0. This holds on every cycle the request is held, until a window shift opens room.
- R5: On a `shift_pulse` cycle, `head_frame` carries the new head value. If that value equals the injection frame, the injection frame moves forward by one and the credit becomes min(reservation, credit + reservation).
- R6: When `shift_pulse` and `req_valid` arrive in the same cycle, the shift adjustment of R5 is applied first. The request is then judged against the adjusted frame and credit.
- R7: Setting `resv_we` loads `resv_val` into the reservation at the clock edge. The credit itself is not changed. The new value is used by later borrow steps and shift refills, not by the write cycle.
- R8: The `inj_frame` tag of an accepted packet never equals `head_frame`. The tag is a frame index from 0 to `W-1`.
- R9: In a cycle with neither a request nor a shift, the injection frame and the credit keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Source offers a packet this cycle |
| req_len | input | LEN_W | Packet length in flits |
| head_frame | input | $clog2(W) | Current head frame index (new value on a shift cycle) |
| shift_pulse | input | 1 | Window shift happens this cycle |
| resv_we | input | 1 | Load a new reservation |
| resv_val | input | RES_W | New reservation in flits per frame |
| inj_accept | output | 1 | Offered packet is accepted this cycle |
| inj_stall | output | 1 | Offered packet must wait |
| inj_frame | output | $clog2(W) | Frame tag of the accepted packet |

## Verification
Directed sequences drive the credit through an exact drain to zero and through an overdraft. Telling these apart confirms that borrowing starts at zero as well as below it. A long packet that exhausts the whole window shows the stall, and also shows that the stall lifts only after enough shifts. Shifts that land on the injection frame, with and without a request in the same cycle, separate "shift first" from "request first" ordering through the tag and the credit seen afterwards. Reservation rewrites, including zero, are followed by drains that expose when the new value is first added. A long pseudo-random phase then mixes all of these against the reference model.

// File: rtl/frame_inject_pkg.sv
package frame_inject_pkg;

    // Index of the frame after f in a ring of w frames.
    function automatic int unsigned wrap_next(int unsigned f, int unsigned w);
        return (f + 1 >= w) ? 0 : f + 1;
    endfunction

endpackage

// File: rtl/frame_shift_adj.sv
// Applies a window shift to the injection frame and credit (shift-first stage).
module frame_shift_adj
    import frame_inject_pkg::*;
#(
    parameter int unsigned W     = 4,
    parameter int unsigned FW    = 2,
    parameter int unsigned CW    = 10,
    parameter int unsigned RES_W = 8
) (
    input  logic                 shift_i,
    input  logic [FW-1:0]        head_i,
    input  logic [FW-1:0]        frame_i,
    input  logic signed [CW-1:0] credit_i,
    input  logic [RES_W-1:0]     resv_i,
    output logic [FW-1:0]        frame_o,
    output logic signed [CW-1:0] credit_o
);
    logic signed [CW-1:0] resv_s;
    logic signed [CW-1:0] sum_s;
    logic                 hit;

    assign resv_s = $signed({{(CW-RES_W){1'b0}}, resv_i});
    assign sum_s  = credit_i + resv_s;
    assign hit    = shift_i && (head_i == frame_i);

    always_comb begin
        frame_o  = frame_i;
        credit_o = credit_i;
        if (hit) begin
            frame_o  = FW'(wrap_next(32'(frame_i), W));
            credit_o = (sum_s > resv_s) ? resv_s : sum_s;
        end
    end
endmodule

// File: rtl/frame_borrow_chain.sv
// Unrolled borrow walk: steps forward while credit <= 0 and the next frame is not the head.
module frame_borrow_chain
    import frame_inject_pkg::*;
#(
    parameter int unsigned W     = 4,
    parameter int unsigned FW    = 2,
    parameter int unsigned CW    = 10,
    parameter int unsigned RES_W = 8
) (
    input  logic [FW-1:0]        head_i,
    input  logic [FW-1:0]        frame_i,
    input  logic signed [CW-1:0] credit_i,
    input  logic [RES_W-1:0]     resv_i,
    output logic [FW-1:0]        frame_o,
    output logic signed [CW-1:0] credit_o,
    output logic                 ok_o
);
    localparam logic signed [CW-1:0] ONE  = CW'(1);
    localparam logic signed [CW-1:0] ZERO = '0;

    logic signed [CW-1:0] resv_s;
    logic [FW-1:0]        fr [W];
    logic signed [CW-1:0] cr [W];

    assign resv_s = $signed({{(CW-RES_W){1'b0}}, resv_i});
    assign fr[0]  = frame_i;
    assign cr[0]  = credit_i;

    for (genvar k = 0; k < W - 1; k++) begin : g_step
        logic [FW-1:0] nxt;
        logic          adv;
        assign nxt       = FW'(wrap_next(32'(fr[k]), W));
        assign adv       = (cr[k] < ONE) && (nxt != head_i);
        assign fr[k+1]   = adv ? nxt : fr[k];
        assign cr[k+1]   = adv ? (cr[k] + resv_s) : cr[k];
    end

    assign frame_o  = fr[W-1];
    assign credit_o = cr[W-1];
    assign ok_o     = cr[W-1] > ZERO;
endmodule

// File: rtl/frame_inject_ctrl.sv
module frame_inject_ctrl
    import frame_inject_pkg::*;
#(
    parameter int unsigned W         = 4,
    parameter int unsigned LEN_W     = 4,
    parameter int unsigned RES_W     = 8,
    parameter int unsigned INIT_RESV = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  req_valid,
    input  logic [LEN_W-1:0]                      req_len,
    input  logic [((W > 1) ? $clog2(W) : 1)-1:0]  head_frame,
    input  logic                                  shift_pulse,
    input  logic                                  resv_we,
    input  logic [RES_W-1:0]                      resv_val,
    output logic                                  inj_accept,
    output logic                                  inj_stall,
    output logic [((W > 1) ? $clog2(W) : 1)-1:0]  inj_frame
);
    localparam int unsigned FW   = (W > 1) ? $clog2(W) : 1;
    localparam int unsigned CW   = ((RES_W > LEN_W) ? RES_W : LEN_W) + 2;
    localparam int          LMAX = (2 ** LEN_W) - 1;

    typedef struct packed {
        logic [FW-1:0]    frame;
        logic [CW-1:0]    credit;
        logic [RES_W-1:0] resv;
    } inj_state_t;

    inj_state_t st_d, st_q;

    logic [FW-1:0]        sh_frame, bw_frame;
    logic signed [CW-1:0] sh_credit, bw_credit, len_s;
    logic                 bw_ok;

    assign len_s = $signed({{(CW-LEN_W){1'b0}}, req_len});

    frame_shift_adj #(.W(W), .FW(FW), .CW(CW), .RES_W(RES_W)) u_shift (
        .shift_i  (shift_pulse),
        .head_i   (head_frame),
        .frame_i  (st_q.frame),
        .credit_i ($signed(st_q.credit)),
        .resv_i   (st_q.resv),
        .frame_o  (sh_frame),
        .credit_o (sh_credit)
    );

    frame_borrow_chain #(.W(W), .FW(FW), .CW(CW), .RES_W(RES_W)) u_borrow (
        .head_i   (head_frame),
        .frame_i  (sh_frame),
        .credit_i (sh_credit),
        .resv_i   (st_q.resv),
        .frame_o  (bw_frame),
        .credit_o (bw_credit),
        .ok_o     (bw_ok)
    );

    always_comb begin
        st_d        = st_q;
        st_d.frame  = sh_frame;
        st_d.credit = sh_credit;
        if (req_valid) begin
            st_d.frame  = bw_frame;
            st_d.credit = bw_ok ? (bw_credit - len_s) : bw_credit;
        end
        if (resv_we) begin
            st_d.resv = resv_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.frame  <= FW'(1);
            st_q.credit <= CW'(INIT_RESV);
            st_q.resv   <= RES_W'(INIT_RESV);
        end else begin
            st_q <= st_d;
        end
    end

    assign inj_accept = req_valid && bw_ok;
    assign inj_stall  = req_valid && !bw_ok;
    assign inj_frame  = bw_frame;

    // R8: an accepted packet is never tagged with the head frame
    p_tag_not_head_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inj_accept |-> (inj_frame != head_frame));

    // R2: overdraft never goes below minus the longest packet
    p_credit_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'($signed(st_q.credit)) >= -LMAX);

    // R5: a shift onto the injection frame pushes the injection frame forward
    p_shift_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_pulse && !req_valid && head_frame == st_q.frame)
        |=> (st_q.frame != $past(st_q.frame)));

    // R9: quiet cycles leave frame and credit untouched
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !shift_pulse)
        |=> ($stable(st_q.frame) && $stable(st_q.credit)));

    // R4: stall and accept are exclusive answers to a request
    p_one_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $onehot({inj_accept, inj_stall}));
endmodule

// File: tb/frame_inject_ctrl_test.sv
`timescale 1ns/1ps
module frame_inject_ctrl_test;
    localparam int W = 4;
    localparam int LEN_W = 4;
    localparam int RES_W = 8;
    localparam int INIT_RESV = 4;

    logic clk = 0;
    logic rst_n = 0;
    logic req_valid = 0;
    logic [LEN_W-1:0] req_len = '0;
    logic [1:0] head_frame = '0;
    logic shift_pulse = 0;
    logic resv_we = 0;
    logic [RES_W-1:0] resv_val = '0;
    logic inj_accept, inj_stall;
    logic [1:0] inj_frame;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_if, m_c, m_r, hf;

    always #4 clk = ~clk;

    frame_inject_ctrl #(.W(W), .LEN_W(LEN_W), .RES_W(RES_W), .INIT_RESV(INIT_RESV)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
        .head_frame(head_frame), .shift_pulse(shift_pulse), .resv_we(resv_we),
        .resv_val(resv_val), .inj_accept(inj_accept), .inj_stall(inj_stall),
        .inj_frame(inj_frame)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input int len, input bit sh, input bit we, input int rv, input string tag);
        int c, f, nxt;
        bit acc;
        @(negedge clk);
        if (sh) hf = (hf + 1) % W;
        req_valid = v; req_len = LEN_W'(len); shift_pulse = sh;
        head_frame = 2'(hf); resv_we = we; resv_val = RES_W'(rv);
        c = m_c; f = m_if; acc = 0;
        if (sh && hf == f) begin
            f = (f + 1) % W;
            c = (c + m_r > m_r) ? m_r : c + m_r;
        end
        if (v) begin
            nxt = (f + 1) % W;
            while (c <= 0 && nxt != hf) begin
                c = c + m_r; f = nxt; nxt = (f + 1) % W;
            end
            acc = (c > 0);
            if (acc) c = c - len;
        end
        #1;
        chk(inj_accept == acc, tag, "accept", int'(inj_accept), int'(acc));
        chk(inj_stall == (v && !acc), tag, "stall", int'(inj_stall), int'(v && !acc));
        if (acc) begin
            chk(int'(inj_frame) == f, tag, "frame tag", int'(inj_frame), f);
            chk(int'(inj_frame) != hf, "R8", "tag vs head", int'(inj_frame), hf);
        end
        m_c = c; m_if = f;
        if (we) m_r = rv;
    endtask

    initial begin
        m_if = 1; m_c = INIT_RESV; m_r = INIT_RESV; hf = 0;
        repeat (3) @(posedge clk);
        #1;
        chk(inj_accept == 0 && inj_stall == 0, "R1", "idle outputs in reset", int'(inj_accept), 0);
        @(negedge clk); rst_n = 1;
        // R1: first packet goes to frame 1
        step(1, 1, 0, 0, 0, "R1");
        // R2: overdraft with a packet longer than remaining credit (3 left, len 5)
        step(1, 5, 0, 0, 0, "R2");
        // R9: quiet cycles
        step(0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, "R9");
        // R3: borrow from next frame, then exact drain to zero and borrow again
        step(1, 2, 0, 0, 0, "R3");
        step(1, 1, 0, 0, 0, "R3");
        step(1, 8, 0, 0, 0, "R2");
        // R4: window exhausted, stall held
        step(1, 1, 0, 0, 0, "R4");
        step(1, 1, 0, 0, 0, "R4");
        step(1, 1, 1, 0, 0, "R4");
        step(1, 1, 0, 0, 0, "R4");
        step(1, 1, 1, 0, 0, "R6");
        // R5: shifts until head reaches the injection frame
        step(0, 0, 1, 0, 0, "R5");
        step(0, 0, 1, 0, 0, "R5");
        step(0, 0, 1, 0, 0, "R5");
        step(1, 3, 0, 0, 0, "R5");
        // R6: shift and request together
        step(1, 2, 1, 0, 0, "R6");
        step(1, 6, 1, 0, 0, "R6");
        step(1, 1, 1, 0, 0, "R6");
        // R7: new reservation used only from later borrows
        step(0, 0, 0, 1, 1, "R7");
        step(1, 9, 0, 0, 0, "R7");
        step(1, 1, 0, 0, 0, "R7");
        step(1, 1, 0, 0, 0, "R7");
        step(1, 1, 0, 1, 6, "R7");
        step(1, 1, 1, 0, 0, "R7");
        step(1, 1, 0, 0, 0, "R7");
        // zero reservation: borrowing cannot help
        step(0, 0, 0, 1, 0, "R7");
        step(1, 15, 0, 0, 0, "R4");
        step(1, 1, 0, 0, 0, "R4");
        step(1, 1, 1, 0, 0, "R4");
        step(0, 0, 0, 1, 5, "R7");
        step(1, 1, 1, 0, 0, "R5");
        // mixed pseudo-random traffic
        begin
            logic [15:0] lf = 16'hACE1;
            for (int i = 0; i < 2000; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                step(lf[0], 1 + int'(lf[4:1]) % 15, lf[7:5] == 3'd0,
                     lf[15:11] == 5'd0, int'(lf[10:8]), "R8");
            end
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog run did not finish actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule